// File: doc/BRIEF.md
# Serial Programming Target Interface

This block is the device-side end of a three-wire serial programming link. While the chip is held in reset, an external programmer drives a serial clock and a data-in line. The block shifts the bits into bytes and frames them into fixed 32-bit instructions. It answers on the data-out line. Before it accepts any programming command, it needs an enable handshake. The programmer can check that handshake, because the block echoes the second byte of the handshake while the third byte comes in.

Once the link is enabled, the programmer fills a page buffer one byte at a time and then commits the whole buffer to a page of the on-chip flash model. Flash can be read back a byte at a time. A small byte-wide EEPROM model can be written and read one location at a time. A busy flag covers a fixed number of system clocks after each page write or EEPROM write, and a poll instruction reports it. The serial clock and data are synchronised into the system clock domain, so the serial clock must run slower than a quarter of the system clock.

Top module: `spt_target`

## Requirements
- R1: The data-in bit is captured on the rising serial-clock edge. The data-out line changes only after a falling serial-clock edge, so it holds steady while the serial clock is high.
- R2: Every instruction is exactly 32 bits long, sent MSB first. Framing always consumes all four bytes, whatever their contents, so a rejected instruction leaves the next one correctly aligned.
- R3: Handshake: byte 0 is 0xAC. During the third byte, data-out returns byte 1 as it was received. If byte 1 equals 0x53, `prog_en` rises once the fourth byte completes; any other byte-1 value leaves `prog_en` low.
- R4: While `prog_en` is low, every load, write, read, poll and EEPROM instruction is ignored. Their fourth response byte is 0x00 and memory is left unchanged.
- R5: Load low (0x40) and load high (0x48) write byte 3 into the low or high half of the page-buffer word selected by byte 2 bits [WORD_BITS-1:0]. The other half keeps its value.
- R6: Write page (0x4C) copies every page-buffer word into the flash page selected by byte 1 bits [PAGE_BITS-1:0]. The word address is {page, offset}.
- R7: Read low (0x20) and read high (0x28) return, during the fourth byte, the flash word half selected by byte 1 (page) and byte 2 (offset). Erased flash reads 0xFF.
- R8: After a page write or an EEPROM write, poll (0xF0) returns 0x01 in the fourth byte for BUSY_CYC system clocks, and 0x00 afterwards.
- R9: EEPROM write (0xC0) stores byte 3 at the address in byte 2 bits [EE_AW-1:0], replacing the old content completely (erase, then write). EEPROM read (0xA0) returns that byte in the fourth byte. Erased EEPROM reads 0xFF.
- R10: A high `tgt_reset` clears `prog_en` and the bit and byte framing, so the next bit starts a new instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; also erases the memory models |
| tgt_reset | input | 1 | Programming-session reset pulse from the programmer |
| sck | input | 1 | Serial clock from the programmer |
| mosi | input | 1 | Serial data into the target |
| miso | output | 1 | Serial data out of the target |
| prog_en | output | 1 | Programming enabled by a valid handshake |

## Verification
The bench fills every page of a small flash configuration with arithmetic patterns and reads back both halves of every word. A page-addressing or half-select error therefore shows up as a wrong byte at a known address. It sends a handshake with a wrong sync byte, then a correct one. A design that drops bytes on a mismatch would misframe the second instruction and never enable. It loads only a low half over a stale buffer, to catch a load that clobbers the other half. It overwrites an EEPROM byte with complementary data, to catch a write that ANDs instead of replacing. It aborts an instruction part-way with `tgt_reset`, to catch framing that survives the abort. It polls the busy flag inside and after its window. It also samples data-out at both ends of each high phase, to catch an output that changes on the wrong edge.

// File: rtl/spt_pkg.sv
package spt_pkg;

    localparam logic [7:0] OP_ENABLE   = 8'hAC;
    localparam logic [7:0] SYNC_BYTE   = 8'h53;
    localparam logic [7:0] OP_LOAD_LO  = 8'h40;
    localparam logic [7:0] OP_LOAD_HI  = 8'h48;
    localparam logic [7:0] OP_WRITE_PG = 8'h4C;
    localparam logic [7:0] OP_READ_LO  = 8'h20;
    localparam logic [7:0] OP_READ_HI  = 8'h28;
    localparam logic [7:0] OP_EE_WR    = 8'hC0;
    localparam logic [7:0] OP_EE_RD    = 8'hA0;
    localparam logic [7:0] OP_POLL     = 8'hF0;

    typedef struct packed {
        logic [7:0] op;
        logic [7:0] b1;
        logic [7:0] b2;
        logic [7:0] b3;
    } instr_t;

    typedef enum logic [1:0] {SLOT_OP, SLOT_B1, SLOT_B2, SLOT_B3} slot_e;

    typedef enum logic [3:0] {
        CMD_NONE, CMD_ENABLE, CMD_LD_LO, CMD_LD_HI, CMD_WR_PG,
        CMD_RD_LO, CMD_RD_HI, CMD_EE_WR, CMD_EE_RD, CMD_POLL
    } cmd_e;

    function automatic cmd_e decode(input logic [7:0] op);
        case (op)
            OP_ENABLE:   return CMD_ENABLE;
            OP_LOAD_LO:  return CMD_LD_LO;
            OP_LOAD_HI:  return CMD_LD_HI;
            OP_WRITE_PG: return CMD_WR_PG;
            OP_READ_LO:  return CMD_RD_LO;
            OP_READ_HI:  return CMD_RD_HI;
            OP_EE_WR:    return CMD_EE_WR;
            OP_EE_RD:    return CMD_EE_RD;
            OP_POLL:     return CMD_POLL;
            default:     return CMD_NONE;
        endcase
    endfunction

endpackage

// File: rtl/spt_sync_edge.sv
module spt_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sck_in,
    input  logic mosi_in,
    output logic rise,
    output logic fall,
    output logic mosi_s
);
    localparam int MSB = STAGES - 1;

    logic [MSB:0] sck_p;
    logic [MSB:0] mosi_p;
    logic         sck_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_p    <= '0;
            mosi_p   <= '0;
            sck_last <= 1'b0;
        end else begin
            sck_p    <= {sck_p[MSB-1:0], sck_in};
            mosi_p   <= {mosi_p[MSB-1:0], mosi_in};
            sck_last <= sck_p[MSB];
        end
    end

    assign rise   = sck_p[MSB] & ~sck_last;
    assign fall   = ~sck_p[MSB] & sck_last;
    assign mosi_s = mosi_p[MSB];
endmodule

// File: rtl/spt_frame.sv
module spt_frame
    import spt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       rise,
    input  logic       fall,
    input  logic       mosi,
    input  logic [7:0] resp,
    output logic       miso,
    output instr_t     instr,
    output logic       exec,
    output slot_e      tx_slot,
    output logic [4:0] bit_cnt
);
    logic [7:0] rx;
    logic [7:0] tx;
    logic [7:0] rx_next;

    assign rx_next = {rx[6:0], mosi};

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            bit_cnt <= '0;
            rx      <= '0;
            tx      <= '0;
            instr   <= '0;
            exec    <= 1'b0;
        end else begin
            exec <= 1'b0;
            if (rise) begin
                rx      <= rx_next;
                bit_cnt <= bit_cnt + 5'd1;
                if (bit_cnt[2:0] == 3'd7) begin
                    case (bit_cnt[4:3])
                        2'd0: instr.op <= rx_next;
                        2'd1: instr.b1 <= rx_next;
                        2'd2: instr.b2 <= rx_next;
                        default: begin
                            instr.b3 <= rx_next;
                            exec     <= 1'b1;
                        end
                    endcase
                end
            end
            if (fall) begin
                if (bit_cnt[2:0] == 3'd0) tx <= resp;
                else                      tx <= {tx[6:0], 1'b0};
            end
        end
    end

    assign tx_slot = slot_e'(bit_cnt[4:3]);
    assign miso    = tx[7];
endmodule

// File: rtl/spt_core.sv
module spt_core
    import spt_pkg::*;
#(
    parameter int WORD_BITS = 4,
    parameter int PAGE_BITS = 6,
    parameter int EE_AW     = 7,
    parameter int BUSY_CYC  = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       exec,
    input  instr_t     instr,
    input  slot_e      tx_slot,
    output logic [7:0] resp,
    output logic       enabled,
    output logic       busy,
    output logic       wr_start
);
    localparam int PAGE_WORDS  = 1 << WORD_BITS;
    localparam int FA          = WORD_BITS + PAGE_BITS;
    localparam int FLASH_WORDS = 1 << FA;
    localparam int EE_BYTES    = 1 << EE_AW;
    localparam int BW          = $clog2(BUSY_CYC + 1);

    logic [15:0] pbuf  [PAGE_WORDS];
    logic [15:0] flash [FLASH_WORDS];
    logic [7:0]  ee    [EE_BYTES];
    logic [BW-1:0] busy_cnt;

    cmd_e                 cmd;
    logic [PAGE_BITS-1:0] page;
    logic [WORD_BITS-1:0] word;
    logic [FA-1:0]        faddr;
    logic [EE_AW-1:0]     ee_a;

    assign cmd      = decode(instr.op);
    assign page     = instr.b1[PAGE_BITS-1:0];
    assign word     = instr.b2[WORD_BITS-1:0];
    assign faddr    = {page, word};
    assign ee_a     = instr.b2[EE_AW-1:0];
    assign wr_start = exec && enabled && (cmd == CMD_WR_PG || cmd == CMD_EE_WR);
    assign busy     = (busy_cnt != '0);

    always_ff @(posedge clk) begin
        if (rst || clr)
            enabled <= 1'b0;
        else if (exec && cmd == CMD_ENABLE && instr.b1 == SYNC_BYTE)
            enabled <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)           busy_cnt <= '0;
        else if (wr_start) busy_cnt <= BW'(BUSY_CYC);
        else if (busy)     busy_cnt <= busy_cnt - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < PAGE_WORDS; i++)  pbuf[i]  <= 16'hFFFF;
            for (int i = 0; i < FLASH_WORDS; i++) flash[i] <= 16'hFFFF;
            for (int i = 0; i < EE_BYTES; i++)    ee[i]    <= 8'hFF;
        end else if (exec && enabled) begin
            case (cmd)
                CMD_LD_LO: pbuf[word][7:0]  <= instr.b3;
                CMD_LD_HI: pbuf[word][15:8] <= instr.b3;
                CMD_WR_PG:
                    for (int i = 0; i < PAGE_WORDS; i++)
                        flash[{page, WORD_BITS'(i)}] <= pbuf[i];
                CMD_EE_WR: ee[ee_a] <= instr.b3;
                default: ;
            endcase
        end
    end

    always_comb begin
        resp = 8'h00;
        case (tx_slot)
            SLOT_B2: if (cmd == CMD_ENABLE) resp = instr.b1;
            SLOT_B3: if (enabled) begin
                case (cmd)
                    CMD_RD_LO: resp = flash[faddr][7:0];
                    CMD_RD_HI: resp = flash[faddr][15:8];
                    CMD_EE_RD: resp = ee[ee_a];
                    CMD_POLL:  resp = {7'b0, busy};
                    default:   resp = 8'h00;
                endcase
            end
            default: resp = 8'h00;
        endcase
    end
endmodule

// File: rtl/spt_target.sv
module spt_target
    import spt_pkg::*;
#(
    parameter int WORD_BITS   = 4,
    parameter int PAGE_BITS   = 6,
    parameter int EE_AW       = 7,
    parameter int BUSY_CYC    = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tgt_reset,
    input  logic sck,
    input  logic mosi,
    output logic miso,
    output logic prog_en
);
    logic       w_rise, w_fall, w_mosi;
    logic [7:0] w_resp;
    instr_t     w_instr;
    logic       w_exec;
    slot_e      w_slot;
    logic [4:0] w_bitcnt;
    logic       w_busy, w_wr_start;

    spt_sync_edge #(.STAGES(SYNC_STAGES)) i_sync (
        .clk(clk), .rst(rst), .sck_in(sck), .mosi_in(mosi),
        .rise(w_rise), .fall(w_fall), .mosi_s(w_mosi)
    );

    spt_frame i_frame (
        .clk(clk), .rst(rst), .clr(tgt_reset), .rise(w_rise), .fall(w_fall),
        .mosi(w_mosi), .resp(w_resp), .miso(miso), .instr(w_instr),
        .exec(w_exec), .tx_slot(w_slot), .bit_cnt(w_bitcnt)
    );

    spt_core #(
        .WORD_BITS(WORD_BITS), .PAGE_BITS(PAGE_BITS),
        .EE_AW(EE_AW), .BUSY_CYC(BUSY_CYC)
    ) i_core (
        .clk(clk), .rst(rst), .clr(tgt_reset), .exec(w_exec), .instr(w_instr),
        .tx_slot(w_slot), .resp(w_resp), .enabled(prog_en),
        .busy(w_busy), .wr_start(w_wr_start)
    );
endmodule

// File: rtl/spt_target_chk.sv
module spt_target_chk (
    input logic       clk,
    input logic       rst,
    input logic       tgt_reset,
    input logic       miso,
    input logic       fall,
    input logic       exec,
    input logic       prog_en,
    input logic [4:0] bit_cnt,
    input logic       busy,
    input logic       wr_start
);
    AST_MISO_HOLDS_OFF_FALL: assert property (@(posedge clk) disable iff (rst)
        (!fall && !tgt_reset) |=> $stable(miso)); // R1

    AST_ENABLE_ONLY_AT_END: assert property (@(posedge clk) disable iff (rst)
        !exec |=> !$rose(prog_en)); // R3

    AST_SESSION_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
        tgt_reset |=> (!prog_en && bit_cnt == 5'd0)); // R10

    AST_BUSY_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
        wr_start |=> busy); // R8

    AST_NO_WRITE_WHEN_LOCKED: assert property (@(posedge clk) disable iff (rst)
        !prog_en |-> !wr_start); // R4
endmodule

bind spt_target spt_target_chk i_chk (
    .clk(clk), .rst(rst), .tgt_reset(tgt_reset), .miso(miso), .fall(w_fall),
    .exec(w_exec), .prog_en(prog_en), .bit_cnt(w_bitcnt), .busy(w_busy),
    .wr_start(w_wr_start)
);

// File: tb/test_spt_target.sv
`timescale 1ns/1ps
module test_spt_target;
    localparam int WB = 4, PB = 2, EA = 3, BUSY = 600, HALF = 6;
    localparam int NW = 1 << WB, NP = 1 << PB, NE = 1 << EA;

    logic clk = 1'b0, rst = 1'b1, tgt_reset = 1'b0, sck = 1'b0, mosi = 1'b0;
    logic miso, prog_en;
    int n_cmp = 0, n_bad = 0;

    always #4 clk = ~clk;

    spt_target #(.WORD_BITS(WB), .PAGE_BITS(PB), .EE_AW(EA), .BUSY_CYC(BUSY)) i_spt_target (
        .clk(clk), .rst(rst), .tgt_reset(tgt_reset), .sck(sck), .mosi(mosi),
        .miso(miso), .prog_en(prog_en)
    );

    function automatic logic [7:0] exp_lo(input int p, input int w);
        return 8'(p * 37 + w * 11 + 5);
    endfunction
    function automatic logic [7:0] exp_hi(input int p, input int w);
        return 8'((p * 91) ^ (w * 13) ^ 8'h5A);
    endfunction
    function automatic logic [7:0] exp_ee(input int a);
        return 8'(a * 29 + 3);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send_bits(input logic [31:0] w, input int n, output logic [31:0] r);
        logic [31:0] late;
        r = '0;
        late = '0;
        for (int i = 31; i > 31 - n; i--) begin
            @(negedge clk);
            mosi = w[i];
            repeat (HALF) @(negedge clk);
            r[i] = miso;
            sck = 1'b1;
            repeat (HALF) @(negedge clk);
            late[i] = miso;
            sck = 1'b0;
        end
        chk("R1 miso steady while sck high", late, r);
    endtask

    task automatic xfer(input logic [7:0] a, b, c, d, output logic [31:0] r);
        send_bits({a, b, c, d}, 32, r);
    endtask

    task automatic wait_idle();
        repeat (BUSY + 50) @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] r;
        logic [15:0] w5;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R10 reset miso", {31'b0, miso}, 32'h0);
        chk("R10 reset prog_en", {31'b0, prog_en}, 32'h0);

        // R4: commands while locked are ignored
        xfer(8'h40, 8'h00, 8'h03, 8'h12, r);
        xfer(8'h4C, 8'h01, 8'h00, 8'h00, r);
        xfer(8'h20, 8'h01, 8'h03, 8'h00, r);
        chk("R4 locked read returns 0", {24'b0, r[7:0]}, 32'h0);
        xfer(8'hC0, 8'h00, 8'h01, 8'h33, r);
        xfer(8'hF0, 8'h00, 8'h00, 8'h00, r);
        chk("R4 locked poll returns 0", {24'b0, r[7:0]}, 32'h0);

        // R3: wrong sync byte echoed, not enabled
        xfer(8'hAC, 8'h52, 8'h00, 8'h00, r);
        chk("R3 echo of wrong sync", {24'b0, r[15:8]}, 32'h52);
        @(negedge clk);
        chk("R3 no enable on mismatch", {31'b0, prog_en}, 32'h0);
        // R2: framing intact after rejected instruction
        xfer(8'hAC, 8'h53, 8'h00, 8'h00, r);
        chk("R3 echo of sync", {24'b0, r[15:8]}, 32'h53);
        @(negedge clk);
        chk("R2 R3 enabled after full frame", {31'b0, prog_en}, 32'h1);

        xfer(8'h20, 8'h01, 8'h03, 8'h00, r);
        chk("R4 R7 locked write left flash erased", {24'b0, r[7:0]}, 32'hFF);
        xfer(8'hA0, 8'h00, 8'h01, 8'h00, r);
        chk("R4 R9 locked ee write ignored", {24'b0, r[7:0]}, 32'hFF);

        // R5 R6: fill every page
        for (int p = 0; p < NP; p++) begin
            for (int w = 0; w < NW; w++) begin
                xfer(8'h40, 8'h00, 8'(w), exp_lo(p, w), r);
                xfer(8'h48, 8'h00, 8'(w), exp_hi(p, w), r);
            end
            xfer(8'h4C, 8'(p), 8'h00, 8'h00, r);
            if (p == 0) begin
                xfer(8'hF0, 8'h00, 8'h00, 8'h00, r);
                chk("R8 busy inside window", {24'b0, r[7:0]}, 32'h1);
                wait_idle();
                xfer(8'hF0, 8'h00, 8'h00, 8'h00, r);
                chk("R8 idle after window", {24'b0, r[7:0]}, 32'h0);
            end else begin
                wait_idle();
            end
        end

        // R7: read back every half of every word
        for (int p = 0; p < NP; p++)
            for (int w = 0; w < NW; w++) begin
                xfer(8'h20, 8'(p), 8'(w), 8'h00, r);
                chk($sformatf("R6 R7 lo p%0d w%0d", p, w), {24'b0, r[7:0]}, {24'b0, exp_lo(p, w)});
                xfer(8'h28, 8'(p), 8'(w), 8'h00, r);
                chk($sformatf("R6 R7 hi p%0d w%0d", p, w), {24'b0, r[7:0]}, {24'b0, exp_hi(p, w)});
            end

        // R5: loading low half keeps stale high half
        xfer(8'h40, 8'h00, 8'h05, 8'hAA, r);
        xfer(8'h4C, 8'h00, 8'h00, 8'h00, r);
        wait_idle();
        xfer(8'h20, 8'h00, 8'h05, 8'h00, r);
        w5[7:0] = r[7:0];
        xfer(8'h28, 8'h00, 8'h05, 8'h00, r);
        w5[15:8] = r[7:0];
        chk("R5 half load keeps other half", {16'b0, w5}, {16'b0, exp_hi(NP - 1, 5), 8'hAA});

        // R9: EEPROM sweep and overwrite
        for (int a = 0; a < NE; a++) xfer(8'hC0, 8'h00, 8'(a), exp_ee(a), r);
        for (int a = 0; a < NE; a++) begin
            xfer(8'hA0, 8'h00, 8'(a), 8'h00, r);
            chk($sformatf("R9 ee addr %0d", a), {24'b0, r[7:0]}, {24'b0, exp_ee(a)});
        end
        xfer(8'hC0, 8'h00, 8'h02, 8'h0F, r);
        xfer(8'hC0, 8'h00, 8'h02, 8'hF0, r);
        xfer(8'hA0, 8'h00, 8'h02, 8'h00, r);
        chk("R9 overwrite replaces", {24'b0, r[7:0]}, 32'hF0);

        // R10: abort mid-instruction
        send_bits({8'h20, 8'h02, 8'h07, 8'h00}, 13, r);
        @(negedge clk);
        tgt_reset = 1'b1;
        repeat (2) @(negedge clk);
        tgt_reset = 1'b0;
        chk("R10 prog_en cleared", {31'b0, prog_en}, 32'h0);
        xfer(8'hAC, 8'h53, 8'h00, 8'h00, r);
        chk("R10 echo after abort", {24'b0, r[15:8]}, 32'h53);
        xfer(8'h28, 8'h02, 8'h07, 8'h00, r);
        chk("R2 R10 framing realigned", {24'b0, r[7:0]}, {24'b0, exp_hi(2, 7)});

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule